// File: doc/BRIEF.md
# Four-Bank Flash Command Interpreter

This block is the control logic of a word-wide parallel NOR flash whose array is split into four banks. It watches bus write cycles (chip-enable and write-enable both low, sampled on the clock), recognises multi-cycle unlock sequences and launches an automatic word program, a sector erase or a whole-array erase. The storage is a small behavioural memory that resets to the erased state. The length of an automatic operation is a parameterised cycle count.

While an operation runs, the banks it occupies answer reads with a status word, and every other bank keeps returning array data. This lets code stored in one bank keep executing while another bank is rewritten. A program can be suspended and resumed by writes to its own bank. A program that asks for a 0 bit to become 1 ends in a timeout state. That state is visible in the status word and is left by a reset command. The ready/busy output tells the host when the automatic logic is occupied.

Top module: `flashci_top`

## Requirements
- R1: After reset, `ry_by` is 1 and every word of the array reads FFFFH.
- R2: With 2^ADDR_W words, addresses below 1/8 of the span are bank 0, below 1/2 are bank 1, below 7/8 are bank 2, and the rest are bank 3. A program occupies only the bank that holds its target word.
- R3: A read (ce_n=0, oe_n=0, we_n=1 for one cycle) to a bank that is not occupied returns that word's array value on `rdata` after the next clock edge. This holds while another bank is busy.
- R4: A read to an occupied bank returns the status word. Bits 15..8 and 4..0 are 0. Bit 7 is the inverse of bit 7 of the data being programmed, and 0 during an erase. Bit 6 is 0 after reset and inverts after every status read. Bit 5 is 1 only in the timeout state.
- R5: Program is AAH at UNL_A, then 55H at UNL_B, then A0H at UNL_A, then the data word at the target address. Command codes are compared on data bits 7..0 only. When the operation finishes, the target word holds the data.
- R6: Sector erase is AAH@UNL_A, 55H@UNL_B, 80H@UNL_A, AAH@UNL_A, 55H@UNL_B, then 30H at any address of the sector. A sector is the 2^SECT_W words that share the address bits above SECT_W. Every word of that sector becomes FFFFH and all other words are unchanged.
- R7: Whole-array erase is the same as R6 except that the last cycle is 10H at UNL_A. All four banks answer with status while it runs, and every word is FFFFH afterwards.
- R8: `ry_by` drops to 0 at the clock edge that samples the final command write. It stays 0 for exactly OP_CYCLES cycles, then returns to 1.
- R9: A write that does not match the next expected cycle abandons the sequence without touching the array. This includes F0H in the third cycle. The write after it is decoded as a first cycle.
- R10: B0H written to any address of the bank being programmed pauses the program and raises `ry_by`. The paused bank then reads array data. 30H to that bank resumes the count where it stopped. B0H to another bank has no effect.
- R11: If the program data has a 1 where the stored word has a 0, the array is left unchanged when the count expires. `ry_by` then stays 0 and status bit 5 reads 1 until F0H is written to any address.
- R12: While an operation is active, paused or timed out, command sequences are not decoded and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data; bits 7..0 carry command codes |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable (read strobe), active low |
| rdata | output | DATA_W | Registered read data or status word |
| ry_by | output | 1 | 1 = ready, 0 = automatic operation busy or timed out |

## Verification
The bench programs words that sit on either side of each bank boundary. While each program runs, it reads every address once. A design that placed a boundary one word off would hand status to a word of a neighbouring bank, or array data to the busy one, and the status reads also check that bit 6 alternates. The `ry_by` window is checked at the last busy cycle and the first ready cycle, which catches a count that is one cycle off.

Broken sequences are each followed by a write that would program a word if the decoder had stayed mid-sequence. This exposes a decoder that fails to fall back. Pausing a program for far longer than OP_CYCLES shows whether the counter keeps running while paused. A program that would set a 0 bit to 1 shows whether the timeout path leaves the word unchanged or wrongly writes it.

// File: rtl/flashci_pkg.sv
package flashci_pkg;

    typedef enum logic [2:0] {
        CMD_RD, CMD_U1, CMD_U2, CMD_PGM, CMD_E3, CMD_E4, CMD_E5
    } cmd_e;

    typedef enum logic [1:0] {OP_IDLE, OP_RUN, OP_SUSP, OP_FAIL} op_e;

    typedef enum logic [1:0] {K_PROG, K_SECT, K_CHIP} kind_e;

    localparam logic [7:0] CODE_UNL1 = 8'hAA;
    localparam logic [7:0] CODE_UNL2 = 8'h55;
    localparam logic [7:0] CODE_PROG = 8'hA0;
    localparam logic [7:0] CODE_ESET = 8'h80;
    localparam logic [7:0] CODE_CHIP = 8'h10;
    localparam logic [7:0] CODE_SECT = 8'h30;
    localparam logic [7:0] CODE_SUSP = 8'hB0;
    localparam logic [7:0] CODE_RSM  = 8'h30;
    localparam logic [7:0] CODE_RST  = 8'hF0;

endpackage

// File: rtl/flashci_bankmap.sv
module flashci_bankmap #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        bank
);
    localparam longint DEPTH = 64'(1) << ADDR_W;

    function automatic longint lim(input int g);
        case (g)
            0:       lim = DEPTH / 8;
            1:       lim = DEPTH / 2;
            default: lim = DEPTH - DEPTH / 8;
        endcase
    endfunction

    logic [2:0] above;

    for (genvar g = 0; g < 3; g++) begin : g_lim
        localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(lim(g));
        assign above[g] = ({1'b0, addr} >= LIM);
    end

    assign bank = 2'(above[0]) + 2'(above[1]) + 2'(above[2]);
endmodule

// File: rtl/flashci_cmddec.sv
module flashci_cmddec
    import flashci_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] UNL_A  = '0,
    parameter logic [ADDR_W-1:0] UNL_B  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        code,
    output logic              start,
    output kind_e             kind,
    output cmd_e              state
);
    cmd_e state_d, state_q;
    logic at_a, at_b;

    assign at_a  = (addr == UNL_A);
    assign at_b  = (addr == UNL_B);
    assign state = state_q;

    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        kind    = K_PROG;
        if (wr) begin
            if (!en) begin
                state_d = CMD_RD;
            end else begin
                unique case (state_q)
                    CMD_RD:  state_d = (at_a && code == CODE_UNL1) ? CMD_U1 : CMD_RD;
                    CMD_U1:  state_d = (at_b && code == CODE_UNL2) ? CMD_U2 : CMD_RD;
                    CMD_U2: begin
                        if (at_a && code == CODE_PROG)      state_d = CMD_PGM;
                        else if (at_a && code == CODE_ESET) state_d = CMD_E3;
                        else                                state_d = CMD_RD;
                    end
                    CMD_PGM: begin
                        start   = 1'b1;
                        kind    = K_PROG;
                        state_d = CMD_RD;
                    end
                    CMD_E3:  state_d = (at_a && code == CODE_UNL1) ? CMD_E4 : CMD_RD;
                    CMD_E4:  state_d = (at_b && code == CODE_UNL2) ? CMD_E5 : CMD_RD;
                    CMD_E5: begin
                        state_d = CMD_RD;
                        if (at_a && code == CODE_CHIP) begin
                            start = 1'b1;
                            kind  = K_CHIP;
                        end else if (code == CODE_SECT) begin
                            start = 1'b1;
                            kind  = K_SECT;
                        end
                    end
                    default: state_d = CMD_RD;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMD_RD;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/flashci_array.sv
module flashci_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cdata,
    input  logic              we_prog,
    input  logic              we_sect,
    input  logic              we_chip
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign hit[g] = we_chip ||
                        (we_sect && ((ADDR_W'(g) >> SECT_W) == (waddr >> SECT_W)));
    end

    assign rdata = mem[raddr];
    assign cdata = mem[waddr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hit[i])
                    mem[i] <= '1;
                else if (we_prog && waddr == ADDR_W'(i))
                    mem[i] <= mem[i] & wdata;
            end
        end
    end

    // R5
    prog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_prog |=> ((cdata & ~$past(cdata)) == '0));

    // R6
    sect_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_sect |=> (cdata == '1));
endmodule

// File: rtl/flashci_top.sv
module flashci_top
    import flashci_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 16,
    parameter int                SECT_W    = 4,
    parameter int                OP_CYCLES = 64,
    parameter logic [ADDR_W-1:0] UNL_A     = ADDR_W'(12'h555),
    parameter logic [ADDR_W-1:0] UNL_B     = ADDR_W'(12'h2AA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              ry_by
);
    localparam int              CNT_W = $clog2(OP_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_CYCLES - 1);

    typedef struct packed {
        op_e               op;
        kind_e             kind;
        logic [ADDR_W-1:0] tgt;
        logic [DATA_W-1:0] dat;
        logic [1:0]        bank;
        logic [CNT_W-1:0]  cnt;
        logic              tog;
        logic [DATA_W-1:0] rd;
    } st_t;

    st_t d, q;

    logic              wr, rd, start, fin, prog_bad;
    logic [7:0]        code;
    logic [1:0]        bus_bank;
    logic [3:0]        busy_mask;
    logic [DATA_W-1:0] arr_rdata, cdata, status;
    kind_e             dec_kind;
    cmd_e              dec_state;

    assign wr   = !ce_n && !we_n;
    assign rd   = !ce_n && !oe_n && we_n;
    assign code = wdata[7:0];

    flashci_bankmap #(.ADDR_W(ADDR_W)) i_bankmap (
        .addr (addr),
        .bank (bus_bank)
    );

    flashci_cmddec #(.ADDR_W(ADDR_W), .UNL_A(UNL_A), .UNL_B(UNL_B)) i_cmddec (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr),
        .en    (q.op == OP_IDLE),
        .addr  (addr),
        .code  (code),
        .start (start),
        .kind  (dec_kind),
        .state (dec_state)
    );

    assign fin      = (q.op == OP_RUN) && (q.cnt == LAST);
    assign prog_bad = (q.kind == K_PROG) && (|(q.dat & ~cdata));

    flashci_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr   (addr),
        .rdata   (arr_rdata),
        .waddr   (q.tgt),
        .wdata   (q.dat),
        .cdata   (cdata),
        .we_prog (fin && q.kind == K_PROG && !prog_bad),
        .we_sect (fin && q.kind == K_SECT),
        .we_chip (fin && q.kind == K_CHIP)
    );

    always_comb begin
        if (q.op == OP_RUN || q.op == OP_FAIL)
            busy_mask = (q.kind == K_CHIP) ? 4'hF : (4'b0001 << q.bank);
        else
            busy_mask = 4'h0;
        status    = '0;
        status[7] = (q.kind == K_PROG) ? ~q.dat[7] : 1'b0;
        status[6] = q.tog;
        status[5] = (q.op == OP_FAIL);
    end

    always_comb begin
        d = q;
        unique case (q.op)
            OP_IDLE: if (start) begin
                d.op   = OP_RUN;
                d.kind = dec_kind;
                d.tgt  = addr;
                d.dat  = wdata;
                d.bank = bus_bank;
                d.cnt  = '0;
            end
            OP_RUN: begin
                if (fin) begin
                    d.op = prog_bad ? OP_FAIL : OP_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                    if (wr && q.kind == K_PROG && bus_bank == q.bank && code == CODE_SUSP)
                        d.op = OP_SUSP;
                end
            end
            OP_SUSP: if (wr && bus_bank == q.bank && code == CODE_RSM) d.op = OP_RUN;
            OP_FAIL: if (wr && code == CODE_RST) d.op = OP_IDLE;
            default: d.op = OP_IDLE;
        endcase
        if (rd) begin
            if (busy_mask[bus_bank]) begin
                d.rd  = status;
                d.tog = ~q.tog;
            end else begin
                d.rd  = arr_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.rd;
    assign ry_by = !(q.op == OP_RUN || q.op == OP_FAIL);

    // R8
    run_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.op == OP_RUN) |-> (q.cnt < CNT_W'(OP_CYCLES)));

    // R10
    susp_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.op == OP_SUSP) |-> (q.kind == K_PROG));

    // R12
    dec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.op != OP_IDLE) |-> (dec_state == CMD_RD));

    // R3
    free_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !busy_mask[bus_bank]) |=> (rdata == $past(arr_rdata)));
endmodule

// File: tb/test_flashci_top.sv
module test_flashci_top;
    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int N   = 1 << AW;
    localparam int OPC = 600;
    localparam int UA  = 'h55;
    localparam int UB  = 'hAA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [DW-1:0] rdata;
    logic          ry_by;

    int          vecs = 0, errs = 0;
    logic        tog_e = 1'b0;
    logic [15:0] m [N];

    always #4 clk = ~clk;

    flashci_top #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(4), .OP_CYCLES(OPC)) i_flashci_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .rdata(rdata), .ry_by(ry_by)
    );

    function automatic int bank_of(input int a);
        if (a < N / 8)          return 0;
        else if (a < N / 2)     return 1;
        else if (a < N - N / 8) return 2;
        return 3;
    endfunction

    task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] v);
        @(negedge clk);
        addr = AW'(a); wdata = v; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        @(negedge clk);
        addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        v = rdata;
    endtask

    task automatic rd_ar(input int a, input string r);
        logic [15:0] v;
        rd(a, v);
        chk(r, v, m[a]);
    endtask

    task automatic rd_st(input int a, input string r, input logic prog,
                         input logic [15:0] dv, input logic to);
        logic [15:0] v, e;
        rd(a, v);
        e = 16'h0000;
        e[7] = prog ? ~dv[7] : 1'b0;
        e[6] = tog_e;
        e[5] = to;
        chk(r, v, e);
        tog_e = ~tog_e;
    endtask

    task automatic prog(input int a, input logic [15:0] v);
        wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(UA, 16'h00A0); wr(a, v);
    endtask

    task automatic wait_ready();
        while (!ry_by) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [15:0] v;
        for (int i = 0; i < N; i++) m[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 ry_by", {15'b0, ry_by}, 16'h0001);
        for (int a = 0; a < N; a++) rd_ar(a, "R1 erased");

        // R2 R3 R4 R5 boundary programs, full read sweep while busy
        begin
            int tg [6] = '{N/8-1, N/8, N/2-1, N/2, N-N/8-1, N-N/8};
            for (int k = 0; k < 6; k++) begin
                logic [15:0] dv;
                dv = 16'(16'h0F81 + k * 16'h2B3D);
                prog(tg[k], dv);
                for (int a = 0; a < N; a++) begin
                    if (bank_of(a) == bank_of(tg[k])) rd_st(a, "R2 R4 busy bank", 1'b1, dv, 1'b0);
                    else                              rd_ar(a, "R2 R3 free bank");
                end
                wait_ready();
                m[tg[k]] = dv;
                rd_ar(tg[k], "R5 programmed");
            end
        end

        // R8 busy window length
        prog(40, 16'hF0F0);
        chk("R8 low at start", {15'b0, ry_by}, 16'h0000);
        repeat (OPC - 1) @(negedge clk);
        chk("R8 low last cycle", {15'b0, ry_by}, 16'h0000);
        @(negedge clk);
        chk("R8 high after", {15'b0, ry_by}, 16'h0001);
        m[40] = 16'hF0F0;
        rd_ar(40, "R5 programmed");

        // R11 timeout on 0->1 request
        prog(40, 16'h0FFF);
        repeat (OPC + 5) @(negedge clk);
        chk("R11 stays busy", {15'b0, ry_by}, 16'h0000);
        rd_st(40, "R11 status bit5", 1'b1, 16'h0FFF, 1'b1);
        rd_ar(200, "R3 other bank in timeout");
        wr(7, 16'h00F0);
        chk("R11 ready after F0", {15'b0, ry_by}, 16'h0001);
        rd_ar(40, "R11 word unchanged");

        // R9 broken sequences
        wr(UA, 16'h00AA); wr(UB, 16'h0012); wr(UA, 16'h00A0); wr(10, 16'h0000);
        chk("R9 bad data no op", {15'b0, ry_by}, 16'h0001);
        rd_ar(10, "R9 bad data array");
        wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(UA, 16'h00F0); wr(10, 16'h0000);
        chk("R9 F0 third no op", {15'b0, ry_by}, 16'h0001);
        rd_ar(10, "R9 F0 third array");
        wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(UA, 16'h0080);
        wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(UA, 16'h0020);
        chk("R9 bad erase no op", {15'b0, ry_by}, 16'h0001);
        wr(UA, 16'h00AA); wr(UB + 1, 16'h0055); wr(UA, 16'h00A0); wr(12, 16'h0000);
        chk("R9 bad addr no op", {15'b0, ry_by}, 16'h0001);
        rd_ar(12, "R9 bad addr array");
        prog(12, 16'h1234);
        wait_ready();
        m[12] = 16'h1234;
        rd_ar(12, "R9 decode resumes");

        // R10 suspend / resume
        prog(5, 16'h4321);
        repeat (10) @(negedge clk);
        wr(200, 16'h00B0);
        chk("R10 other bank B0 ignored", {15'b0, ry_by}, 16'h0000);
        wr(9, 16'h00B0);
        chk("R10 suspended ready", {15'b0, ry_by}, 16'h0001);
        rd_ar(9, "R10 suspended bank array");
        rd_ar(5, "R10 target not yet written");
        repeat (2 * OPC) @(negedge clk);
        chk("R10 stays suspended", {15'b0, ry_by}, 16'h0001);
        rd_ar(5, "R10 still unwritten");
        wr(9, 16'h0030);
        chk("R10 resumed busy", {15'b0, ry_by}, 16'h0000);
        wait_ready();
        m[5] = 16'h4321;
        rd_ar(5, "R10 completed");

        // R12 commands ignored while busy
        prog(230, 16'h00AA);
        prog(0, 16'h0000);
        wait_ready();
        m[230] = 16'h00AA;
        rd_ar(0, "R12 ignored program");
        rd_ar(230, "R12 first program");

        // R6 sector erase
        wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(UA, 16'h0080);
        wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(45, 16'h0030);
        rd_st(45, "R4 R6 erase status", 1'b0, 16'h0000, 1'b0);
        rd_ar(10, "R3 during sector erase");
        wait_ready();
        for (int a = 32; a < 48; a++) m[a] = 16'hFFFF;
        for (int a = 0; a < N; a++) rd_ar(a, "R6 sweep");

        // R7 whole-array erase
        wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(UA, 16'h0080);
        wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(UA, 16'h0010);
        rd_st(3,   "R7 bank0 status", 1'b0, 16'h0000, 1'b0);
        rd_st(100, "R7 bank1 status", 1'b0, 16'h0000, 1'b0);
        rd_st(150, "R7 bank2 status", 1'b0, 16'h0000, 1'b0);
        rd_st(250, "R7 bank3 status", 1'b0, 16'h0000, 1'b0);
        wait_ready();
        for (int a = 0; a < N; a++) m[a] = 16'hFFFF;
        for (int a = 0; a < N; a++) rd_ar(a, "R7 sweep");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule